// File: doc/BRIEF.md
# Lane-Local Byte Shuffler

This block rearranges the bytes of a 256-bit vector. The vector is treated as two separate 16-byte lanes, and a control vector of the same width chooses the contents of each output byte. The control byte at output position i names a source byte inside the lane that holds i. It may also force the output byte to zero. A lane never reads from the other lane.

An optional merge step uses the top bit of each control byte a second time. When merging is enabled, a byte whose top bit is set takes the matching byte of a third vector (`in_dst`) instead of zero. This produces a shuffle and a partial overwrite of an existing vector in one pass.

The datapath is combinational up to a single output register. Inputs and results move over valid/ready handshakes:
- An input beat is accepted when `in_valid` and `in_ready` are both high at a clock edge.
- A result leaves when `out_valid` and `out_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being emptied in the same cycle.
- A result held under back-pressure keeps its value until it is taken.

Top module: `lane_byte_shuffler`

## Requirements
- R1: Output byte i, when bit 7 of control byte i is clear, equals the source byte at position L*16 + ctrl_i[3:0], where L is the lane of i (0 for bytes 0..15, 1 for bytes 16..31).
- R2: In the upper lane an index counts from byte 16, so control value 0 at an upper-lane position yields source byte 16, never a lower-lane byte.
- R3: Bits 6:4 of a control byte have no effect; for example, index 0x71 selects the same byte as 0x01.
- R4: With merging disabled, any output byte whose control bit 7 is set is 0x00, whatever bits 6:0 hold.
- R5: A single source byte may be copied to several output bytes of its lane in the same beat.
- R6: With merging enabled, a byte whose control bit 7 is set takes the `in_dst` byte at the same position, and every other byte takes the shuffled byte.
- R7: With merging disabled, `in_dst` has no effect on the result.
- R8: A beat accepted at a clock edge appears with `out_valid` high right after that same edge (one cycle of latency).
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged at the next edge.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.
- R11: An identity control vector (byte i holds i mod 16) returns `in_src` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_src | input | 256 | Source bytes |
| in_ctrl | input | 256 | One control byte per output byte |
| in_dst | input | 256 | Bytes merged in where control bit 7 is set |
| in_blend_en | input | 1 | Enables the merge with `in_dst` |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Registered result |

## Verification
The shuffle is driven with these control patterns, each of which separates one mistake from correct behaviour:

- **Identity and in-lane reversal.** These catch an index that is flipped or offset.
- **All-zero control.** Each lane is filled with its own first byte, so this shows whether an upper-lane index wrongly reaches the lower lane.
- **Identity with bits 6:4 set.** This must match plain identity, so it shows whether the ignored bits leak into the index.
- **Bit 7 set, merge off and on, with a non-zero `in_dst`.** These separate forced zero, merged destination byte and an ignored `in_dst`.
- **Random beats under a random `out_ready`.** These check the scoreboard order and show whether a result held under back-pressure changes.

// File: rtl/shuffle_pkg.sv
package shuffle_pkg;
  localparam int BYTE_W     = 8;
  localparam int LANE_BYTES = 16;
  localparam int NUM_LANES  = 2;
  localparam int VEC_BYTES  = LANE_BYTES * NUM_LANES;
  localparam int VEC_W      = VEC_BYTES * BYTE_W;
endpackage

// File: rtl/shuf_byte_pick.sv
// One output byte: a lane-wide multiplexer plus a force-to-zero on the top control bit.
module shuf_byte_pick #(
  parameter int BYTE_W     = 8,
  parameter int LANE_BYTES = 16,
  localparam int IDX_W     = $clog2(LANE_BYTES),
  localparam int LANE_W    = LANE_BYTES * BYTE_W
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] sel_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              kill_o
);
  logic [IDX_W-1:0] idx;
  logic             unused_mid_bits;

  assign idx             = sel_i[IDX_W-1:0];
  assign kill_o          = sel_i[BYTE_W-1];
  assign unused_mid_bits = ^sel_i[BYTE_W-2:IDX_W];

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < LANE_BYTES; k++) begin
      if (idx == IDX_W'(k)) byte_o = lane_i[k*BYTE_W +: BYTE_W];
    end
    if (kill_o) byte_o = '0;
  end
endmodule

// File: rtl/shuf_lane.sv
// One lane: every output byte gets its own picker over this lane's source bytes.
module shuf_lane #(
  parameter int BYTE_W     = 8,
  parameter int LANE_BYTES = 16,
  localparam int LANE_W    = LANE_BYTES * BYTE_W
) (
  input  logic [LANE_W-1:0]     src_i,
  input  logic [LANE_W-1:0]     ctrl_i,
  output logic [LANE_W-1:0]     shuf_o,
  output logic [LANE_BYTES-1:0] kill_o
);
  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_pick
    shuf_byte_pick #(.BYTE_W(BYTE_W), .LANE_BYTES(LANE_BYTES)) u_pick (
      .lane_i (src_i),
      .sel_i  (ctrl_i[b*BYTE_W +: BYTE_W]),
      .byte_o (shuf_o[b*BYTE_W +: BYTE_W]),
      .kill_o (kill_o[b])
    );
  end
endmodule

// File: rtl/shuf_blend.sv
// Per-byte merge: a killed byte takes the destination byte when merging is on.
module shuf_blend #(
  parameter int BYTE_W    = 8,
  parameter int VEC_BYTES = 32,
  localparam int VEC_W    = VEC_BYTES * BYTE_W
) (
  input  logic [VEC_W-1:0]     shuf_i,
  input  logic [VEC_W-1:0]     dst_i,
  input  logic [VEC_BYTES-1:0] kill_i,
  input  logic                 en_i,
  output logic [VEC_W-1:0]     res_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_mix
    assign res_o[b*BYTE_W +: BYTE_W] = (en_i && kill_i[b]) ? dst_i[b*BYTE_W +: BYTE_W]
                                                           : shuf_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/shuf_out_stage.sv
// Single register slot with a valid/ready handshake on both sides.
module shuf_out_stage #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/lane_byte_shuffler.sv
module lane_byte_shuffler
  import shuffle_pkg::*;
#(
  parameter int BW    = BYTE_W,
  parameter int LB    = LANE_BYTES,
  parameter int NL    = NUM_LANES,
  localparam int NB   = LB * NL,
  localparam int LW   = LB * BW,
  localparam int W    = NB * BW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_ctrl,
  input  logic [W-1:0] in_dst,
  input  logic         in_blend_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0]  shuf;
  logic [NB-1:0] kill;
  logic [W-1:0]  merged;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    shuf_lane #(.BYTE_W(BW), .LANE_BYTES(LB)) u_lane (
      .src_i  (in_src [l*LW +: LW]),
      .ctrl_i (in_ctrl[l*LW +: LW]),
      .shuf_o (shuf   [l*LW +: LW]),
      .kill_o (kill   [l*LB +: LB])
    );
  end

  shuf_blend #(.BYTE_W(BW), .VEC_BYTES(NB)) u_blend (
    .shuf_i (shuf),
    .dst_i  (in_dst),
    .kill_i (kill),
    .en_i   (in_blend_en),
    .res_o  (merged)
  );

  shuf_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (merged),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/shuf_checker.sv
module shuf_checker #(
  parameter int BW = 8,
  parameter int W  = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_ctrl,
  input logic [W-1:0] in_dst,
  input logic         in_blend_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  logic take;
  assign take = in_valid && in_ready;

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_zero_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_blend_en && in_ctrl[BW-1]) |=> (out_data[BW-1:0] == '0));

  assert_merge_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_blend_en && in_ctrl[BW-1]) |=> (out_data[BW-1:0] == $past(in_dst[BW-1:0])));

  assert_merge_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_blend_en && in_ctrl[W-1]) |=> (out_data[W-1 -: BW] == $past(in_dst[W-1 -: BW])));
endmodule

bind lane_byte_shuffler shuf_checker #(.BW(BW), .W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_ctrl     (in_ctrl),
  .in_dst      (in_dst),
  .in_blend_en (in_blend_en),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/sim_lane_byte_shuffler.sv
module sim_lane_byte_shuffler;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_src = '0, in_ctrl = '0, in_dst = '0;
  logic         in_blend_en = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit stall  = 1'b0;
  bit done   = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  lane_byte_shuffler u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_ctrl(in_ctrl), .in_dst(in_dst), .in_blend_en(in_blend_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] s, c, d, input logic b);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      logic [7:0] cb;
      int         lane;
      cb   = c[i*8 +: 8];
      lane = i / 16;
      if (cb[7]) r[i*8 +: 8] = b ? d[i*8 +: 8] : 8'h00;
      else       r[i*8 +: 8] = s[(lane*16 + int'(cb[3:0]))*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [W-1:0] s, c, d, input logic b);
    @(negedge clk);
    in_src = s; in_ctrl = c; in_dst = d; in_blend_en = b; in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    exp_q.push_back(model(s, c, d, b));
    tag_q.push_back(tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin : monitor
    bit           held;
    logic [W-1:0] held_data;
    held = 1'b0;
    held_data = '0;
    forever begin
      @(negedge clk);
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (held) begin
        // R9: a result held under back-pressure must not move or vanish
        check("R9 hold valid", {255'd0, out_valid}, {255'd0, 1'b1});
        check("R9 hold data", out_data, held_data);
      end
      held = rst_n && out_valid && !out_ready;
      held_data = out_data;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R8: actual unexpected output %h expected none", out_data);
        end else begin
          string t;
          t = tag_q.pop_front();
          check(t, out_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    wait (cycles > 100000 || done);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] s, c, d, ident;
    for (int i = 0; i < 32; i++) ident[i*8 +: 8] = 8'(i % 16);
    s = '0;
    for (int i = 0; i < 32; i++) s[i*8 +: 8] = 8'(8'hA0 + i);
    d = '0;
    for (int i = 0; i < 32; i++) d[i*8 +: 8] = 8'(8'h40 + i);

    repeat (3) @(negedge clk);
    #3;
    // R10: reset state
    check("R10 out_valid in reset", {255'd0, out_valid}, '0);
    check("R10 in_ready in reset", {255'd0, in_ready}, {255'd0, 1'b1});
    @(negedge clk) rst_n = 1'b1;
    #3;
    check("R10 out_valid after reset", {255'd0, out_valid}, '0);

    // R11: identity
    send("R11 identity", s, ident, d, 1'b0);
    // R8: result visible right after the accepting edge
    @(negedge clk); #3;
    check("R8 latency", {255'd0, out_valid}, {255'd1});
    check("R11 identity direct", out_data, s);

    // R1: reverse within each lane
    c = '0;
    for (int i = 0; i < 32; i++) c[i*8 +: 8] = 8'(15 - (i % 16));
    send("R1 lane reverse", s, c, d, 1'b0);

    // R2 / R5: all-zero control fans lane byte 0 out, upper lane uses byte 16
    send("R2 R5 zero control", s, '0, d, 1'b0);
    c = '0;
    for (int i = 0; i < 32; i++) c[i*8 +: 8] = 8'(i % 3);
    send("R5 fan-out", s, c, d, 1'b0);

    // R3: bits 6:4 ignored -> same as identity
    c = '0;
    for (int i = 0; i < 32; i++) c[i*8 +: 8] = 8'((i % 16) | ((i % 8) << 4));
    send("R3 ignored bits", s, c, d, 1'b0);
    exp_q[exp_q.size()-1] = s;

    // R4 / R7: top bit zeroes, dst has no effect without merge
    c = ident;
    for (int i = 0; i < 32; i += 3) c[i*8 +: 8] = (i % 2 == 0) ? 8'hFF : 8'h85;
    send("R4 R7 zero no merge", s, c, d, 1'b0);
    send("R7 dst ignored", s, c, ~d, 1'b0);

    // R6: merge with dst
    send("R6 merge", s, c, d, 1'b1);
    send("R6 merge all", s, {32{8'h80}}, d, 1'b1);
    exp_q[exp_q.size()-1] = d;

    // R1..R7 random beats, then R9 under back-pressure
    for (int n = 0; n < 40; n++) send("R1 R6 random", rnd_vec(), rnd_vec(), rnd_vec(), n[0]);
    stall = 1'b1;
    for (int n = 0; n < 60; n++) send("R9 random stalled", rnd_vec(), rnd_vec(), rnd_vec(), n[1]);
    stall = 1'b0;

    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule